// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the target side of a half-duplex serial register bus built from three lines: an active-low frame enable, a serial clock, and one shared data line. The host opens a frame by pulling the enable low, then clocks in a nine-bit header that holds an eight-bit register address with a direction flag placed inside it. On a write the host then sends a 16-bit word, which lands in a small register file inside the block. On a read the host lets go of the data line for half a clock. The block then drives the 16-bit contents of the addressed register back out.

All three bus lines are sampled by a fast system clock, passed through synchronizer stages, and turned into edge events. The serial side therefore needs no clock of its own. The shared data line is split at the port into a sampled input, a driven value and a drive enable, and the pad sits outside the block. The serial clock idles low between frames.

Top module: `tw_reg_slave`

## Requirements
- R1: While reset is asserted and right after it is released, `sdio_oe` is 0 and every register reads back as 0x0000.
- R2: Clock edges and data seen while `sen_n` is high are ignored. No register changes, and `sdio_oe` is 0 within a few system clocks after `sen_n` rises.
- R3: The header is nine bits, sampled on rising serial clock edges in this order: address bits 7, 6 and 5, then the direction flag, then address bits 4 down to 0. A flag value of 1 selects a read and 0 selects a write.
- R4: On a write, 16 data bits follow the header, most significant bit first, each sampled on a rising edge. The word is stored in the addressed register only once the sixteenth bit has been sampled.
- R5: On a read, the block starts driving on the falling edge that follows the ninth rising edge, which gives a half-clock turnaround. It launches each new bit on a falling edge, bit 15 first. It returns the register value as it was when the header ended.
- R6: If `sen_n` rises before the sixteenth write data bit, or during the header, the frame is abandoned and no register changes.
- R7: Addresses at or above NUM_REGS (default 8) are not backed by storage. Writes to them are dropped, and reads from them return 0x0000.
- R8: On the falling edge after the sixteenth read bit has been sampled, the block releases the data line (`sdio_oe` = 0).
- R9: The block never drives the data line during the header or during write data.
- R10: Serial clocks that arrive after a complete write or read, before `sen_n` rises, have no effect: no extra write and no further drive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| sen_n | input | 1 | Active-low frame enable from the host |
| sclk | input | 1 | Serial clock from the host, idle low |
| sdio_i | input | 1 | Sampled level of the shared data line |
| sdio_o | output | 1 | Data value the block drives onto the line |
| sdio_oe | output | 1 | Drive enable for the data line, 1 = block drives |

## Verification
The framing state and the register file can only be seen through reads. A wrong header decode, a misplaced direction flag or a write that is dropped or misdirected therefore shows up on the next read of an affected address, as wrong bits from the first sampled rising edge onward. Errors in drive control show up at once, within the synchronizer latency: a drive enable that overlaps the host's own driving is flagged on the clock where the overlap happens. A late or missing release is caught at the falling edge where the line should go quiet. Aborts and trailing clocks are followed by read-backs, which expose any stray commit.

// File: rtl/tw_pkg.sv
package tw_pkg;

  // header: A7 A6 A5 RW A4 A3 A2 A1 A0, first bit ends up at index 8
  localparam int HDR_BITS = 9;
  localparam int ADDR_W   = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_WDATA,
    ST_RDATA,
    ST_DONE
  } tw_state_e;

  function automatic logic [ADDR_W-1:0] hdr_addr(input logic [HDR_BITS-1:0] h);
    return {h[8:6], h[4:0]};
  endfunction

  function automatic logic hdr_is_read(input logic [HDR_BITS-1:0] h);
    return h[5];
  endfunction

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sen_n,
  input  logic sclk,
  input  logic sdio_i,
  output logic sen_high,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic sdio_bit
);
  localparam int LANES = 3;
  // lane order: 0 = sclk, 1 = enable, 2 = data
  localparam logic [LANES-1:0] RST_PAT = 3'b110;

  logic [LANES-1:0] raw;
  logic [LANES-1:0] synced;
  logic             sclk_q;

  assign raw = {sdio_i, sen_n, sclk};

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_PAT[ln]}};
      else        chain <= {chain[STAGES-2:0], raw[ln]};
    end
    assign synced[ln] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= synced[0];
  end

  assign sclk_rise = synced[0] & ~sclk_q;
  assign sclk_fall = ~synced[0] & sclk_q;
  assign sen_high  = synced[1];
  assign sdio_bit  = synced[2];

  // edges are exclusive events
  p_edge_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_rise && sclk_fall));

endmodule

// File: rtl/tw_frame.sv
module tw_frame
  import tw_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sen_high,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              sdio_bit,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              sdio_o,
  output logic              sdio_oe
);
  localparam int MAXB  = (DATA_W > HDR_BITS) ? DATA_W : HDR_BITS;
  localparam int CNT_W = $clog2(MAXB + 1);

  tw_state_e             state;
  logic [CNT_W-1:0]      cnt;
  logic [HDR_BITS-1:0]   hdr_q;
  logic [HDR_BITS-1:0]   hdr_n;
  logic [ADDR_W-1:0]     addr_q;
  logic [DATA_W-1:0]     wsh;
  logic [DATA_W-1:0]     rsh;
  logic                  hdr_last;
  logic                  wr_last;

  assign hdr_n    = {hdr_q[HDR_BITS-2:0], sdio_bit};
  assign hdr_last = (state == ST_HDR) && sclk_rise && (cnt == CNT_W'(HDR_BITS - 1));
  assign wr_last  = (state == ST_WDATA) && sclk_rise && (cnt == CNT_W'(DATA_W - 1));

  assign rd_addr = hdr_addr(hdr_n);
  assign wr_en   = wr_last && !sen_high;
  assign wr_addr = addr_q;
  assign wr_data = {wsh[DATA_W-2:0], sdio_bit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      hdr_q   <= '0;
      addr_q  <= '0;
      wsh     <= '0;
      rsh     <= '0;
      sdio_o  <= 1'b0;
      sdio_oe <= 1'b0;
    end else if (sen_high) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      sdio_oe <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          state <= ST_HDR;
          cnt   <= '0;
        end
        ST_HDR: if (sclk_rise) begin
          hdr_q <= hdr_n;
          if (hdr_last) begin
            addr_q <= hdr_addr(hdr_n);
            cnt    <= '0;
            if (hdr_is_read(hdr_n)) begin
              rsh   <= rd_data;
              state <= ST_RDATA;
            end else begin
              state <= ST_WDATA;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WDATA: if (sclk_rise) begin
          wsh <= wr_data;
          cnt <= cnt + 1'b1;
          if (wr_last) state <= ST_DONE;
        end
        ST_RDATA: if (sclk_fall) begin
          if (cnt < CNT_W'(DATA_W)) begin
            sdio_o  <= rsh[DATA_W-1];
            rsh     <= {rsh[DATA_W-2:0], 1'b0};
            sdio_oe <= 1'b1;
            cnt     <= cnt + 1'b1;
          end else begin
            sdio_oe <= 1'b0;
            state   <= ST_DONE;
          end
        end
        ST_DONE: ;
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_no_drive_hdr_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HDR || state == ST_WDATA) |-> !sdio_oe);

  p_launch_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdio_oe) |-> $past(sclk_fall));

  p_data_moves_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_fall |=> $stable(sdio_o));

  p_single_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (state == ST_DONE || state == ST_IDLE) && !wr_en);

  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE) |-> !wr_en && !sdio_oe);

endmodule

// File: rtl/tw_regfile.sv
module tw_regfile
  import tw_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic [DATA_W-1:0]              mem [NUM_REGS];
  logic [NUM_REGS*DATA_W-1:0]     mem_flat;
  logic                           wr_hit;
  logic                           rd_hit;
  logic [IDX_W-1:0]               wr_idx;
  logic [IDX_W-1:0]               rd_idx;

  function automatic logic in_range(input logic [ADDR_W-1:0] a);
    return int'(a) < NUM_REGS;
  endfunction

  assign wr_hit = in_range(wr_addr);
  assign rd_hit = in_range(rd_addr);
  assign wr_idx = wr_addr[IDX_W-1:0];
  assign rd_idx = rd_addr[IDX_W-1:0];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                        mem[g] <= '0;
      else if (wr_en && wr_hit && wr_idx == IDX_W'(g))   mem[g] <= wr_data;
    end
    assign mem_flat[g*DATA_W +: DATA_W] = mem[g];
  end

  assign rd_data = rd_hit ? mem[rd_idx] : '0;

  p_oor_write_dropped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hit) |=> $stable(mem_flat));

  p_idle_no_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem_flat));

  p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_hit) |=> mem[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/tw_reg_slave.sv
module tw_reg_slave
  import tw_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NUM_REGS    = 8,
  parameter int DATA_W      = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sen_n,
  input  logic sclk,
  input  logic sdio_i,
  output logic sdio_o,
  output logic sdio_oe
);
  logic              sen_high;
  logic              sclk_rise;
  logic              sclk_fall;
  logic              sdio_bit;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;

  tw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sen_n     (sen_n),
    .sclk      (sclk),
    .sdio_i    (sdio_i),
    .sen_high  (sen_high),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .sdio_bit  (sdio_bit)
  );

  tw_frame #(.DATA_W(DATA_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .sen_high  (sen_high),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .sdio_bit  (sdio_bit),
    .rd_data   (rd_data),
    .rd_addr   (rd_addr),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .sdio_o    (sdio_o),
    .sdio_oe   (sdio_oe)
  );

  tw_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  p_abort_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sen_high |-> !wr_en);

  p_release_on_disable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sen_high |=> !sdio_oe);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> !sdio_oe);

endmodule

// File: tb/tw_reg_slave_test.sv
`timescale 1ns/1ps
module tw_reg_slave_test;
  localparam int H  = 8;   // system clocks per serial clock phase
  localparam int NR = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sen_n = 1'b1;
  logic sclk = 1'b0;
  logic host_en = 1'b0;
  logic host_val = 1'b1;
  logic sdio_o, sdio_oe;
  logic bus;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int sen_hi_cnt = 0;
  logic [15:0] model [NR];

  always #5 clk = ~clk;

  assign bus = sdio_oe ? sdio_o : (host_en ? host_val : 1'b1);

  tw_reg_slave uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .sen_n   (sen_n),
    .sclk    (sclk),
    .sdio_i  (bus),
    .sdio_o  (sdio_o),
    .sdio_oe (sdio_oe)
  );

  task automatic fail(input string req, input int act, input int exp);
    errors++;
    $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) fail(req, act, exp);
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // per-clock reference: drive ownership and idle release
  always @(negedge clk) begin
    cyc++;
    if (sen_n) sen_hi_cnt++; else sen_hi_cnt = 0;
    if (rst_n) begin
      checks++;
      if (host_en && sdio_oe) fail("R9 contention", 1, 0);
      if (sen_hi_cnt >= 5 && sdio_oe) fail("R2/R8 idle drive", 1, 0);
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic bitc(input logic v);
    sclk = 1'b0; host_val = v; waitn(H);
    sclk = 1'b1; waitn(H);
  endtask

  // header order R3: A7 A6 A5 RW A4..A0
  task automatic header(input logic rw, input logic [7:0] a, input int nb);
    logic [8:0] h;
    h = {a[7:5], rw, a[4:0]};
    for (int i = 8; i >= 9 - nb; i--) bitc(h[i]);
  endtask

  task automatic finish_frame();
    sclk = 1'b0; waitn(H);
    sen_n = 1'b1; host_en = 1'b0; waitn(3 * H);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [15:0] d,
                          input int nbits, input int extra);
    sen_n = 1'b0; host_en = 1'b1; waitn(H);
    header(1'b0, a, 9);
    for (int i = 15; i >= 16 - nbits; i--) bitc(d[i]);
    for (int i = 0; i < extra; i++) bitc(i[0]);
    finish_frame();
    if (nbits == 16 && a < NR) model[a[2:0]] = d;
  endtask

  task automatic do_read(input logic [7:0] a, input int extra, input string req);
    logic [15:0] exp;
    logic [15:0] got;
    exp = (a < NR) ? model[a[2:0]] : 16'h0000;
    got = '0;
    sen_n = 1'b0; host_en = 1'b1; waitn(H);
    header(1'b1, a, 9);
    host_en = 1'b0;
    for (int i = 15; i >= 0; i--) begin
      sclk = 1'b0; waitn(H);
      checks++;
      if (!sdio_oe) fail({req, " R5 drive"}, 0, 1);
      got[i] = bus;
      sclk = 1'b1; waitn(H);
    end
    check({req, " R5 word"}, got, exp);
    sclk = 1'b0; waitn(H);
    check("R8 release", sdio_oe, 0);
    for (int i = 0; i < extra; i++) begin
      bitc(1'b0);
      check("R10 no drive after read", sdio_oe, 0);
    end
    sen_n = 1'b1; waitn(3 * H);
  endtask

  initial begin
    for (int i = 0; i < NR; i++) model[i] = 16'h0000;
    waitn(5);
    check("R1 oe in reset", sdio_oe, 0);
    rst_n = 1'b1;
    waitn(4);
    check("R1 oe after reset", sdio_oe, 0);
    for (int i = 0; i < NR; i++) do_read(8'(i), 0, "R1 reset value");

    // R4 basic write and read-back
    do_write(8'h03, 16'hA5C3, 16, 0);
    do_read(8'h03, 0, "R4 write A5C3");
    do_write(8'h00, 16'h8001, 16, 0);
    do_write(8'h07, 16'h7FFE, 16, 0);
    do_write(8'h05, 16'hFFFF, 16, 0);
    do_write(8'h01, 16'h1234, 16, 0);
    for (int i = 0; i < NR; i++) do_read(8'(i), 0, "R3 R4 multi");

    // R7 / R3: high address bits land next to the flag
    do_write(8'h25, 16'hDEAD, 16, 0);
    do_read(8'h05, 0, "R7 alias untouched");
    do_read(8'h25, 0, "R7 oor read zero");
    do_write(8'hE3, 16'h0BAD, 16, 0);
    do_read(8'h03, 0, "R7 alias untouched");
    do_read(8'hFF, 0, "R7 oor read zero");

    // R6 abort mid data and mid header
    do_write(8'h02, 16'h5555, 10, 0);
    do_read(8'h02, 0, "R6 abort data");
    do_write(8'h02, 16'h5555, 15, 0);
    do_read(8'h02, 0, "R6 abort 15 bits");
    sen_n = 1'b0; host_en = 1'b1; waitn(H);
    header(1'b0, 8'h06, 5);
    finish_frame();
    do_read(8'h06, 0, "R6 abort header");

    // R2 clocks with enable high
    host_en = 1'b1;
    for (int i = 0; i < 30; i++) bitc(i[1]);
    host_en = 1'b0;
    sclk = 1'b0; waitn(2 * H);
    check("R2 idle oe", sdio_oe, 0);
    for (int i = 0; i < NR; i++) do_read(8'(i), 0, "R2 no change");

    // R10 trailing clocks after complete transfers
    do_write(8'h04, 16'hC0DE, 16, 5);
    do_read(8'h04, 4, "R10 trailing write");
    do_read(8'h07, 6, "R10 trailing read");

    // R5 alternating patterns
    do_write(8'h06, 16'hAAAA, 16, 0);
    do_read(8'h06, 0, "R5 pattern AAAA");
    do_write(8'h06, 16'h0001, 16, 0);
    do_read(8'h06, 0, "R5 pattern 0001");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule